// File: doc/BRIEF.md
# Dual-Port Message and Signal Register Bank

This block is a small bank of 16-bit registers that two masters in the same clock domain share. One master is a local processor on a short offset port. The other is a backplane master that addresses the bank inside a 16-bit address space. The bank holds an outgoing and an incoming message register, each with a full flag. It also holds a two-slot signal queue, a constant protocol word, a test-and-set lock that serialises competing senders, and a status word with a soft-reset bit and a ready bit.

The backplane window is 64 bytes wide. It starts at 0xC000 plus 0x40 times the 8-bit logical address, so logical address 0x00 places it at 0xC000 and 0x25 places it at 0xC940. Both ports use the same byte offsets inside the window. Each access is a one-cycle request pulse, and the acknowledge and read data follow one cycle later. The local master issues no new request until it has seen its acknowledge.

If both ports reach the same offset in the same cycle, the backplane access takes effect first and the local access is held for one cycle. Register offsets: 0x00 status, 0x02 protocol/signal, 0x04 message, 0x06 lock, 0x08 signal slot 0, 0x0A signal slot 1.

Status word bits:

| Bit | Meaning |
|---|---|
| 0 | soft reset |
| 1 | ready |
| 2 | response write-ready, which is 1 when the outgoing register is empty |
| 3 | incoming message waiting |
| 4 | signal present |
| 5 | oldest-slot index |
| 6 | sticky queue overflow |
| 7 | lock free |
| 15:8 | always 0 |

Top module: `dpmsg_top`

## Requirements
- R1: A backplane request is acknowledged one cycle later exactly when bp_addr[15:6] equals 0x300 plus the logical address; any other address gets no acknowledge.
- R2: A read of offset 0x02 from either port returns the constant PROTO_WORD (default 0xA5F0).
- R3: A write of offset 0x02 from either port places the value in a free signal slot and sets status bit 4. The slots are read by the local port at 0x08 and 0x0A, and a local read of a valid slot frees it.
- R4: While status bit 4 is 1, status bit 5 gives the slot (0 or 1) holding the oldest signal. Signals come out oldest first when slots are read in that order.
- R5: A signal write while both slots are full is dropped and sets status bit 6. The bit stays set until a status write with bit 6 = 1.
- R6: A local write to 0x04 fills the outgoing register, and a backplane read of 0x04 returns it. A backplane write to 0x04 fills the incoming register and sets status bit 3, and a local read of 0x04 returns it and clears bit 3.
- R7: Status bit 2 reads 0 from a local message write until the backplane reads the message, and reads 1 otherwise.
- R8: A read of 0x06 returns 1 and takes the lock when the lock is free, and returns 0 when it is held. Any write to 0x06 frees it. Status bit 7 shows the lock as free.
- R9: Odd offsets, offsets above 0x0A and the slot offsets seen from the backplane read 0xFFFF, and writes to them change nothing.
- R10: Status bit 1 (ready) is written only by the local port. While status bit 0 (soft reset, writable from both ports) is 1, ready reads 0 and cannot be set.
- R11: When both ports access the same offset in one cycle, the backplane access is acknowledged after one cycle and the local one after two. The local access sees the backplane access's effect.
- R12: After reset, both acknowledges are 0 and the status word reads 0x0084.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| la | input | 8 | Logical address that selects the backplane window |
| bp_req | input | 1 | Backplane request pulse |
| bp_we | input | 1 | Backplane write when 1, read when 0 |
| bp_addr | input | 16 | Backplane byte address |
| bp_wdata | input | 16 | Backplane write data |
| bp_ack | output | 1 | Backplane acknowledge, one cycle after a hit |
| bp_rdata | output | 16 | Backplane read data, valid with bp_ack |
| lcl_req | input | 1 | Local request pulse |
| lcl_we | input | 1 | Local write when 1, read when 0 |
| lcl_addr | input | 6 | Local byte offset in the window |
| lcl_wdata | input | 16 | Local write data |
| lcl_ack | output | 1 | Local acknowledge |
| lcl_rdata | output | 16 | Local read data, valid with lcl_ack |

## Verification
A wrong oldest-slot pointer or a lost slot-valid bit shows in status bits 4 and 5 at the very next status read. It also shows as signals coming out of the slots in the wrong order. Stuck message or lock flags show as a wrong status bit 2, 3 or 7, or as a lock read returning the wrong value, within one access of the event that should have changed them. A faulty collision rule shows as a local acknowledge on the wrong cycle, or as a local lock read that returns 1 after the backplane already took the lock.

// File: rtl/dpmsg_pkg.sv
package dpmsg_pkg;
    localparam int DW    = 16;
    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] IX_STAT  = 6'h00;
    localparam logic [OFS_W-1:0] IX_PROTO = 6'h02;
    localparam logic [OFS_W-1:0] IX_MSG   = 6'h04;
    localparam logic [OFS_W-1:0] IX_LOCK  = 6'h06;
    localparam logic [OFS_W-1:0] IX_SLOT0 = 6'h08;
    localparam logic [OFS_W-1:0] IX_SLOT1 = 6'h0A;

    typedef struct packed {
        logic          srst;
        logic          ready;
        logic          out_full;
        logic          in_full;
        logic [DW-1:0] out_msg;
        logic [DW-1:0] in_msg;
        logic [1:0]    sv;      // slot valid bits
        logic          head;    // slot holding the oldest signal
        logic          ovf;
        logic          locked;
        logic [DW-1:0] slot0;
        logic [DW-1:0] slot1;
    } bank_t;

    function automatic logic [DW-1:0] status_word(bank_t b);
        return {8'h00, !b.locked, b.ovf, (|b.sv) & b.head, |b.sv,
                b.in_full, !b.out_full, b.ready, b.srst};
    endfunction

    // One access applied to the bank; returns the new bank, read data through rd.
    function automatic bank_t apply_op(bank_t s, logic from_bp, logic we,
                                       logic [OFS_W-1:0] ix, logic [DW-1:0] wd,
                                       logic [DW-1:0] proto, output logic [DW-1:0] rd);
        bank_t n;
        logic  k;
        n  = s;
        rd = '1;
        k  = s.sv[s.head] ? !s.head : s.head;
        case (ix)
            IX_STAT: begin
                rd = status_word(s);
                if (we) begin
                    n.srst = wd[0];
                    if (!from_bp) n.ready = wd[1];
                    if (wd[6])    n.ovf   = 1'b0;
                end
            end
            IX_PROTO: begin
                rd = proto;
                if (we) begin
                    if (&s.sv) n.ovf = 1'b1;
                    else begin
                        if (k) n.slot1 = wd;
                        else   n.slot0 = wd;
                        n.sv[k] = 1'b1;
                    end
                end
            end
            IX_MSG: begin
                if (we) begin
                    if (from_bp) begin n.in_msg  = wd; n.in_full  = 1'b1; end
                    else         begin n.out_msg = wd; n.out_full = 1'b1; end
                end else if (from_bp) begin
                    rd = s.out_msg; n.out_full = 1'b0;
                end else begin
                    rd = s.in_msg;  n.in_full  = 1'b0;
                end
            end
            IX_LOCK: begin
                if (we) n.locked = 1'b0;
                else begin
                    rd = {{(DW-1){1'b0}}, !s.locked};
                    n.locked = 1'b1;
                end
            end
            IX_SLOT0, IX_SLOT1: begin
                if (!from_bp && !we) begin
                    rd = ix[1] ? s.slot1 : s.slot0;
                    if (s.sv[ix[1]]) begin
                        n.sv[ix[1]] = 1'b0;
                        if (s.head == ix[1]) n.head = !s.head;
                    end
                end
            end
            default: ;
        endcase
        if (n.srst) n.ready = 1'b0;
        return n;
    endfunction
endpackage

// File: rtl/dpmsg_bp_decode.sv
module dpmsg_bp_decode #(
    parameter int              AW    = 16,
    parameter int              LA_W  = 8,
    parameter int              OFS_W = 6,
    parameter logic [AW-1:0]   BASE  = 16'hC000
) (
    input  logic             req,
    input  logic [AW-1:0]    addr,
    input  logic [LA_W-1:0]  la,
    output logic             hit,
    output logic [OFS_W-1:0] ofs
);
    localparam int TAG_W = AW - OFS_W;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[AW-1:OFS_W];

    logic [TAG_W-1:0] want;
    assign want = BASE_TAG + TAG_W'(la);
    assign hit  = req && (addr[AW-1:OFS_W] == want);
    assign ofs  = addr[OFS_W-1:0];
endmodule

// File: rtl/dpmsg_arb.sv
module dpmsg_arb #(
    parameter int OFS_W = 6
) (
    input  logic             bp_hit,
    input  logic [OFS_W-1:0] bp_ofs,
    input  logic             lcl_req,
    input  logic [OFS_W-1:0] lcl_ofs,
    input  logic             pend_v,
    output logic             conflict,
    output logic             go_new
);
    logic same;
    assign same     = bp_hit && (bp_ofs == lcl_ofs);
    assign conflict = lcl_req && !pend_v && same;
    assign go_new   = lcl_req && !pend_v && !same;
endmodule

// File: rtl/dpmsg_top.sv
module dpmsg_top
    import dpmsg_pkg::*;
#(
    parameter logic [15:0] PROTO_WORD = 16'hA5F0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  la,
    input  logic        bp_req,
    input  logic        bp_we,
    input  logic [15:0] bp_addr,
    input  logic [15:0] bp_wdata,
    output logic        bp_ack,
    output logic [15:0] bp_rdata,
    input  logic        lcl_req,
    input  logic        lcl_we,
    input  logic [5:0]  lcl_addr,
    input  logic [15:0] lcl_wdata,
    output logic        lcl_ack,
    output logic [15:0] lcl_rdata
);
    typedef struct packed {
        bank_t            bank;
        logic             pend_v;
        logic             pend_we;
        logic [OFS_W-1:0] pend_ofs;
        logic [DW-1:0]    pend_wd;
        logic             bp_ack;
        logic [DW-1:0]    bp_rd;
        logic             lc_ack;
        logic [DW-1:0]    lc_rd;
    } state_t;

    state_t cur_q, nxt_d;

    logic             bp_hit;
    logic [OFS_W-1:0] bp_ix;
    logic             conflict, go_new;
    logic             loc_run, loc_we;
    logic [OFS_W-1:0] loc_ix;
    logic [DW-1:0]    loc_wd;
    logic [DW-1:0]    bp_rd_c, lc_rd_c;
    bank_t            bank_q;

    dpmsg_bp_decode #(.AW(16), .LA_W(8), .OFS_W(OFS_W)) u_dec (
        .req(bp_req), .addr(bp_addr), .la(la), .hit(bp_hit), .ofs(bp_ix)
    );

    dpmsg_arb #(.OFS_W(OFS_W)) u_arb (
        .bp_hit(bp_hit), .bp_ofs(bp_ix), .lcl_req(lcl_req), .lcl_ofs(lcl_addr),
        .pend_v(cur_q.pend_v), .conflict(conflict), .go_new(go_new)
    );

    assign loc_run = cur_q.pend_v || go_new;
    assign loc_we  = cur_q.pend_v ? cur_q.pend_we  : lcl_we;
    assign loc_ix  = cur_q.pend_v ? cur_q.pend_ofs : lcl_addr;
    assign loc_wd  = cur_q.pend_v ? cur_q.pend_wd  : lcl_wdata;
    assign bank_q  = cur_q.bank;

    always_comb begin
        bank_t b;
        nxt_d   = cur_q;
        b       = cur_q.bank;
        bp_rd_c = '1;
        lc_rd_c = '1;
        if (bp_hit)  b = apply_op(b, 1'b1, bp_we, bp_ix, bp_wdata, PROTO_WORD, bp_rd_c);
        if (loc_run) b = apply_op(b, 1'b0, loc_we, loc_ix, loc_wd, PROTO_WORD, lc_rd_c);
        nxt_d.bank     = b;
        nxt_d.pend_v   = conflict;
        nxt_d.pend_we  = lcl_we;
        nxt_d.pend_ofs = lcl_addr;
        nxt_d.pend_wd  = lcl_wdata;
        nxt_d.bp_ack   = bp_hit;
        nxt_d.bp_rd    = bp_hit  ? bp_rd_c : '0;
        nxt_d.lc_ack   = loc_run;
        nxt_d.lc_rd    = loc_run ? lc_rd_c : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign bp_ack    = cur_q.bp_ack;
    assign bp_rdata  = cur_q.bp_rd;
    assign lcl_ack   = cur_q.lc_ack;
    assign lcl_rdata = cur_q.lc_rd;
endmodule

// File: rtl/dpmsg_chk.sv
module dpmsg_chk
    import dpmsg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       la,
    input logic             bp_req,
    input logic [15:0]      bp_addr,
    input logic             bp_ack,
    input logic             lcl_ack,
    input bank_t            bank,
    input logic             bp_hit,
    input logic             bp_we,
    input logic [OFS_W-1:0] bp_ix,
    input logic             loc_run,
    input logic             loc_we,
    input logic [OFS_W-1:0] loc_ix,
    input logic             conflict,
    input logic             pend_v
);
    a_r1_window_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && bp_addr[15:6] == (10'h300 + {2'b00, la})) |=> bp_ack);

    a_r1_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_req |=> !bp_ack);

    a_r4_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank.sv) |-> bank.sv[bank.head]);

    a_r5_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank.ovf) |-> $past(bank.sv) == 2'b11);

    a_r8_lock_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank.locked) |-> $past((bp_hit && !bp_we && bp_ix == IX_LOCK) ||
                                      (loc_run && !loc_we && loc_ix == IX_LOCK)));

    a_r10_srst_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bank.srst |-> !bank.ready);

    a_r11_defer_one: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> (pend_v && !lcl_ack));

    a_r11_defer_done: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v |=> lcl_ack);
endmodule

bind dpmsg_top dpmsg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .la(la), .bp_req(bp_req), .bp_addr(bp_addr),
    .bp_ack(bp_ack), .lcl_ack(lcl_ack), .bank(bank_q), .bp_hit(bp_hit),
    .bp_we(bp_we), .bp_ix(bp_ix), .loc_run(loc_run), .loc_we(loc_we),
    .loc_ix(loc_ix), .conflict(conflict), .pend_v(cur_q.pend_v)
);

// File: tb/tb_dpmsg_top.sv
module tb_dpmsg_top;
    localparam logic [15:0] PROTO = 16'hA5F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  la = 8'h00;
    logic        bp_req = 1'b0, bp_we = 1'b0;
    logic [15:0] bp_addr = '0, bp_wdata = '0;
    logic        bp_ack;
    logic [15:0] bp_rdata;
    logic        lcl_req = 1'b0, lcl_we = 1'b0;
    logic [5:0]  lcl_addr = '0;
    logic [15:0] lcl_wdata = '0;
    logic        lcl_ack;
    logic [15:0] lcl_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dpmsg_top dut (
        .clk(clk), .rst_n(rst_n), .la(la),
        .bp_req(bp_req), .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
        .bp_ack(bp_ack), .bp_rdata(bp_rdata),
        .lcl_req(lcl_req), .lcl_we(lcl_we), .lcl_addr(lcl_addr), .lcl_wdata(lcl_wdata),
        .lcl_ack(lcl_ack), .lcl_rdata(lcl_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bp_op(input logic we, input logic [15:0] addr, input logic [15:0] wd,
                         output logic [15:0] rd, output logic ack);
        @(negedge clk);
        bp_req = 1'b1; bp_we = we; bp_addr = addr; bp_wdata = wd;
        @(negedge clk);
        bp_req = 1'b0;
        rd = bp_rdata; ack = bp_ack;
    endtask

    task automatic lcl_op(input logic we, input logic [5:0] a, input logic [15:0] wd,
                          output logic [15:0] rd);
        @(negedge clk);
        lcl_req = 1'b1; lcl_we = we; lcl_addr = a; lcl_wdata = wd;
        @(negedge clk);
        lcl_req = 1'b0;
        rd = lcl_rdata;
        if (!lcl_ack) begin
            n_chk++; n_fail++;
            $display("FAIL local ack: got 0 expected 1");
        end
    endtask

    task automatic status_is(input string req, input logic [15:0] exp);
        logic [15:0] r;
        lcl_op(1'b0, 6'h00, 16'h0, r);
        check(req, r, exp);
    endtask

    task automatic t_reset;
        check("R12 bp_ack", {15'd0, bp_ack}, 16'h0);
        check("R12 lcl_ack", {15'd0, lcl_ack}, 16'h0);
        status_is("R12 status", 16'h0084);
    endtask

    task automatic t_decode;
        logic [15:0] r; logic a;
        la = 8'h25;
        bp_op(1'b0, 16'hC942, 16'h0, r, a);
        check("R1 hit la=25 ack", {15'd0, a}, 16'h1);
        check("R2 proto via bp", r, PROTO);
        bp_op(1'b0, 16'hC002, 16'h0, r, a);
        check("R1 miss la=25", {15'd0, a}, 16'h0);
        la = 8'h00;
        bp_op(1'b0, 16'hC002, 16'h0, r, a);
        check("R1 hit la=0", {15'd0, a}, 16'h1);
        bp_op(1'b0, 16'hC942, 16'h0, r, a);
        check("R1 miss la=0", {15'd0, a}, 16'h0);
    endtask

    task automatic t_proto;
        logic [15:0] r;
        lcl_op(1'b0, 6'h02, 16'h0, r);
        check("R2 proto via local", r, PROTO);
    endtask

    task automatic t_fifo;
        logic [15:0] r; logic a;
        bp_op(1'b1, 16'hC002, 16'h1111, r, a);
        lcl_op(1'b1, 6'h02, 16'h2222, r);
        status_is("R3 present, R4 oldest=0", 16'h0094);
        lcl_op(1'b0, 6'h08, 16'h0, r);
        check("R3 slot0 first", r, 16'h1111);
        status_is("R4 oldest=1", 16'h00B4);
        bp_op(1'b1, 16'hC002, 16'h3333, r, a);
        lcl_op(1'b0, 6'h0A, 16'h0, r);
        check("R4 slot1 oldest", r, 16'h2222);
        status_is("R4 oldest back to 0", 16'h0094);
        lcl_op(1'b0, 6'h08, 16'h0, r);
        check("R4 reused slot0", r, 16'h3333);
        status_is("R3 empty", 16'h0084);
    endtask

    task automatic t_ovf;
        logic [15:0] r; logic a;
        bp_op(1'b1, 16'hC002, 16'h4444, r, a);
        lcl_op(1'b1, 6'h02, 16'h5555, r);
        bp_op(1'b1, 16'hC002, 16'h6666, r, a);
        status_is("R5 overflow set, R4 oldest=1", 16'h00F4);
        lcl_op(1'b0, 6'h0A, 16'h0, r);
        check("R5 slot1 kept", r, 16'h4444);
        lcl_op(1'b0, 6'h08, 16'h0, r);
        check("R5 slot0 kept, third dropped", r, 16'h5555);
        status_is("R5 sticky", 16'h00C4);
        lcl_op(1'b1, 6'h00, 16'h0040, r);
        status_is("R5 cleared", 16'h0084);
    endtask

    task automatic t_msg;
        logic [15:0] r; logic a;
        lcl_op(1'b1, 6'h04, 16'hBEEF, r);
        status_is("R7 write-ready low", 16'h0080);
        bp_op(1'b0, 16'hC004, 16'h0, r, a);
        check("R6 outgoing to bp", r, 16'hBEEF);
        status_is("R7 write-ready back", 16'h0084);
        bp_op(1'b1, 16'hC004, 16'h1234, r, a);
        status_is("R6 incoming waiting", 16'h008C);
        lcl_op(1'b0, 6'h04, 16'h0, r);
        check("R6 incoming to local", r, 16'h1234);
        status_is("R6 incoming cleared", 16'h0084);
    endtask

    task automatic t_lock;
        logic [15:0] r; logic a;
        bp_op(1'b0, 16'hC006, 16'h0, r, a);
        check("R8 first take", r, 16'h0001);
        lcl_op(1'b0, 6'h06, 16'h0, r);
        check("R8 held", r, 16'h0000);
        status_is("R8 status held", 16'h0004);
        lcl_op(1'b1, 6'h06, 16'h0, r);
        bp_op(1'b0, 16'hC006, 16'h0, r, a);
        check("R8 after release", r, 16'h0001);
        bp_op(1'b1, 16'hC006, 16'h0, r, a);
        status_is("R8 freed", 16'h0084);
    endtask

    task automatic t_reserved;
        logic [15:0] r; logic a;
        lcl_op(1'b1, 6'h0C, 16'h0000, r);
        lcl_op(1'b0, 6'h0C, 16'h0, r);
        check("R9 local reserved", r, 16'hFFFF);
        bp_op(1'b1, 16'hC003, 16'h0000, r, a);
        bp_op(1'b0, 16'hC003, 16'h0, r, a);
        check("R9 bp odd offset", r, 16'hFFFF);
        bp_op(1'b0, 16'hC008, 16'h0, r, a);
        check("R9 bp slot offset", r, 16'hFFFF);
        status_is("R9 status untouched", 16'h0084);
    endtask

    task automatic t_ready;
        logic [15:0] r; logic a;
        lcl_op(1'b1, 6'h00, 16'h0002, r);
        status_is("R10 local sets ready", 16'h0086);
        bp_op(1'b1, 16'hC000, 16'h0000, r, a);
        status_is("R10 bp cannot clear ready", 16'h0086);
        bp_op(1'b1, 16'hC000, 16'h0001, r, a);
        status_is("R10 srst clears ready", 16'h0085);
        lcl_op(1'b1, 6'h00, 16'h0003, r);
        status_is("R10 ready held low in srst", 16'h0085);
        lcl_op(1'b1, 6'h00, 16'h0000, r);
        bp_op(1'b1, 16'hC000, 16'h0002, r, a);
        status_is("R10 bp cannot set ready", 16'h0084);
    endtask

    task automatic t_conflict;
        logic [15:0] r;
        @(negedge clk);
        bp_req = 1'b1; bp_we = 1'b0; bp_addr = 16'hC006;
        lcl_req = 1'b1; lcl_we = 1'b0; lcl_addr = 6'h06;
        @(negedge clk);
        bp_req = 1'b0; lcl_req = 1'b0;
        check("R11 bp first ack", {15'd0, bp_ack}, 16'h1);
        check("R11 bp got lock", bp_rdata, 16'h0001);
        check("R11 local not yet", {15'd0, lcl_ack}, 16'h0);
        @(negedge clk);
        check("R11 local ack next", {15'd0, lcl_ack}, 16'h1);
        check("R11 local sees bp effect", lcl_rdata, 16'h0000);
        lcl_op(1'b1, 6'h06, 16'h0, r);
        status_is("R11 released", 16'h0084);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_decode;
        t_proto;
        t_fifo;
        t_ovf;
        t_msg;
        t_lock;
        t_reserved;
        t_ready;
        t_conflict;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule